// File: doc/BRIEF.md
# Program Counter Sequencer with Context-Banked Flags

This block keeps the 12-bit program counter of a small 8-bit core, together with a six-entry hardware return-address stack and three copies of the carry/zero flag pair. The core gives it one operation code per cycle: increment, jump, subroutine call, return, maskable interrupt entry, non-maskable interrupt entry or return from interrupt. The sequencer updates the program counter, pushes and pops return addresses, and switches which flag copy the ALU sees.

After reset the block fetches a two-byte start address from the top of program space through a synchronous read port. Only then does it raise `ready_o`. The return stack has its own storage and is not mapped into any address space. It is shared between calls and interrupts. Pushing onto a full stack or popping an empty one sets a sticky error flag. A small context stack records the context that was active before each interrupt entry. Because of this, a non-maskable interrupt can nest inside a maskable one and both can unwind in the right order.

Top module: `pc_seq`

## Requirements
- R1: After reset the block reads address FFEh and then FFFh, one cycle each, with `pmem_rd_o` high. Read data arrives one cycle after the address. The program counter becomes {FFFh byte[3:0], FFEh byte}. `ready_o` rises on the third rising edge after reset is released and then stays high.
- R2: Operation 1 (increment) adds one to the program counter, wrapping from FFFh to 000h. Operation 2 (jump) loads `target_i`.
- R3: Operation 3 (call) pushes the program counter plus 2 and loads `target_i`. Operation 4 (return) loads the most recent pushed address in one cycle and removes it from the stack.
- R4: The return stack holds six entries. A push while six entries are held discards the oldest entry, keeps the depth at six and sets the sticky `ovf_o`.
- R5: A return (operation 4) or interrupt return (operation 7) with an empty stack sets the sticky `unf_o`, leaves the program counter unchanged and leaves the depth at zero.
- R6: Operation 5 (interrupt entry) and operation 6 (NMI entry) both push the current program counter and load `target_i`. They set `ctx_o` to 1 (interrupt) and 2 (NMI) respectively. `ctx_o` 0 means normal and 3 never occurs.
- R7: Operation 7 (interrupt return) pops the return stack and restores the context that was active before the matching entry. A two-deep context stack lets an NMI inside an interrupt return to the interrupt and then to normal. If the context stack is empty, the context becomes normal. If the context stack is full, a new entry drops its oldest record.
- R8: `carry_o` and `zero_o` show the flag pair of the current context. When `flag_we_i` is high, `carry_i` and `zero_i` are written into the pair of the context active in that cycle. The other two pairs keep their values.
- R9: While `ready_o` is low, all operations (0 is no-op) are ignored and the program counter only takes the fetched start address.
- R10: While reset is asserted and right after it, `ctx_o` is 0, `depth_o` is 0, `ovf_o` and `unf_o` are 0, and `ready_o` is 0. The flag values are undefined until they are first written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code for this cycle |
| target_i | input | 12 | Jump, call or interrupt target address |
| flag_we_i | input | 1 | Write enable for the active flag pair |
| carry_i | input | 1 | Carry value to write |
| zero_i | input | 1 | Zero value to write |
| pmem_data_i | input | 8 | Program-memory read data, one cycle after the address |
| pmem_rd_o | output | 1 | Program-memory read strobe during the start-address fetch |
| pmem_addr_o | output | 12 | Program-memory read address |
| ready_o | output | 1 | Start address loaded; operations accepted |
| pc_o | output | 12 | Program counter |
| carry_o | output | 1 | Carry of the active flag pair |
| zero_o | output | 1 | Zero of the active flag pair |
| ctx_o | output | 2 | Context: 0 normal, 1 interrupt, 2 NMI |
| depth_o | output | 3 | Number of valid return-stack entries |
| ovf_o | output | 1 | Sticky return-stack overflow |
| unf_o | output | 1 | Sticky return-stack underflow |

## Verification
The assertions assume that the core presents exactly one operation code per cycle, so a push and a pop never happen in the same cycle. They also assume that the program-memory port returns data one cycle after the address. The stimulus meets these assumptions by construction. Every cycle it picks one of the eight codes, and the bench memory model is registered. Random sequences deliberately include interrupt entries while already inside an interrupt, returns on an empty stack and operations issued during the start-address fetch. These cases exercise the overflow, underflow and ignore paths instead of avoiding them.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP, OP_INC, OP_JMP, OP_CALL, OP_RET, OP_IRQ, OP_NMI, OP_RETI
  } op_e;

  typedef enum logic [1:0] {
    CTX_NORM = 2'd0, CTX_IRQ = 2'd1, CTX_NMI = 2'd2
  } ctx_e;

  typedef enum logic [1:0] {FS_LO, FS_HI, FS_LOAD, FS_RUN} fs_e;
endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [AW-1:0]              data_i,
  output logic [AW-1:0]              top_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == FULL);
  assign top_o   = mem[0];
  assign depth_o = cnt_q;

  // entry 0 is the top; pushes shift toward the bottom, dropping the oldest
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem[0] <= data_i;
      for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
    end else if (pop_i && !empty_o) begin
      for (int i = 0; i < DEPTH-1; i++) mem[i] <= mem[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (push_i) begin
      if (full) ovf_o <= 1'b1;
      else      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      if (empty_o) unf_o <= 1'b1;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_depth_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_full_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> (ovf_o && depth_o == FULL));
  assert_unf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
  assert_push_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full) |=> (depth_o == $past(depth_o) + 1'b1 && top_o == $past(data_i)));
  assert_pop_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (depth_o == $past(depth_o) - 1'b1));
endmodule

// File: rtl/pc_flag_banks.sv
module pc_flag_banks
  import pc_seq_pkg::*;
#(
  parameter int CTX_DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_irq_i,
  input  logic       enter_nmi_i,
  input  logic       leave_i,
  input  logic       we_i,
  input  logic       c_i,
  input  logic       z_i,
  output logic [1:0] ctx_o,
  output logic       c_o,
  output logic       z_o
);
  localparam int NB = 3;
  localparam int KW = $clog2(CTX_DEPTH+1);
  localparam logic [KW-1:0] KFULL = KW'(CTX_DEPTH);

  ctx_e          ctx_q;
  ctx_e          cstk [CTX_DEPTH];
  logic [KW-1:0] ccnt_q;
  logic [NB-1:0] c_bank, z_bank;
  logic          enter;

  assign enter = enter_irq_i | enter_nmi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q  <= CTX_NORM;
      ccnt_q <= '0;
      for (int i = 0; i < CTX_DEPTH; i++) cstk[i] <= CTX_NORM;
    end else if (enter) begin
      cstk[0] <= ctx_q;
      for (int i = 1; i < CTX_DEPTH; i++) cstk[i] <= cstk[i-1];
      if (ccnt_q != KFULL) ccnt_q <= ccnt_q + 1'b1;
      ctx_q <= enter_nmi_i ? CTX_NMI : CTX_IRQ;
    end else if (leave_i) begin
      if (ccnt_q != '0) begin
        ctx_q  <= cstk[0];
        for (int i = 0; i < CTX_DEPTH-1; i++) cstk[i] <= cstk[i+1];
        ccnt_q <= ccnt_q - 1'b1;
      end else begin
        ctx_q <= CTX_NORM;
      end
    end
  end

  // flag pairs are deliberately left without reset
  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [1:0] BI = 2'(b);
    always_ff @(posedge clk_i) begin
      if (we_i && ctx_q == BI) begin
        c_bank[b] <= c_i;
        z_bank[b] <= z_i;
      end
    end
  end

  assign ctx_o = ctx_q;
  assign c_o   = c_bank[ctx_q];
  assign z_o   = z_bank[ctx_q];

  assert_ctx_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_o != 2'd3);
  assert_nmi_enter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_nmi_i |=> ctx_o == 2'd2);
  assert_leave_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leave_i && !enter && ccnt_q == '0) |=> ctx_o == 2'd0);
  assert_flag_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !enter && !leave_i) |=> (c_o == $past(c_i) && z_o == $past(z_i)));
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DEPTH     = 6,
  parameter int CTX_DEPTH = 2,
  parameter int CALL_LEN  = 2,
  parameter logic [11:0] RST_VEC = 12'hFFE
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 op_i,
  input  logic [AW-1:0]              target_i,
  input  logic                       flag_we_i,
  input  logic                       carry_i,
  input  logic                       zero_i,
  input  logic [7:0]                 pmem_data_i,
  output logic                       pmem_rd_o,
  output logic [AW-1:0]              pmem_addr_o,
  output logic                       ready_o,
  output logic [AW-1:0]              pc_o,
  output logic                       carry_o,
  output logic                       zero_o,
  output logic [1:0]                 ctx_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int HW = AW - 8;
  localparam logic [AW-1:0] VEC_LO = AW'(RST_VEC);
  localparam logic [AW-1:0] VEC_HI = VEC_LO + 1'b1;

  fs_e           fs_q;
  logic [7:0]    lo_q;
  logic [AW-1:0] pc_q, push_data, stk_top;
  logic          push, pop, stk_empty, run;
  op_e           op;

  assign op  = op_e'(op_i);
  assign run = (fs_q == FS_RUN);

  always_comb begin
    push      = run && (op == OP_CALL || op == OP_IRQ || op == OP_NMI);
    pop       = run && (op == OP_RET || op == OP_RETI);
    push_data = (op == OP_CALL) ? pc_q + AW'(CALL_LEN) : pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q <= FS_LO;
      lo_q <= '0;
      pc_q <= '0;
    end else begin
      unique case (fs_q)
        FS_LO:   fs_q <= FS_HI;
        FS_HI: begin
          lo_q <= pmem_data_i;
          fs_q <= FS_LOAD;
        end
        FS_LOAD: begin
          pc_q <= {pmem_data_i[HW-1:0], lo_q};
          fs_q <= FS_RUN;
        end
        FS_RUN: begin
          unique case (op)
            OP_INC:                  pc_q <= pc_q + 1'b1;
            OP_JMP, OP_CALL,
            OP_IRQ, OP_NMI:          pc_q <= target_i;
            OP_RET, OP_RETI:         if (!stk_empty) pc_q <= stk_top;
            default: ;
          endcase
        end
      endcase
    end
  end

  assign pmem_rd_o   = (fs_q == FS_LO) || (fs_q == FS_HI);
  assign pmem_addr_o = (fs_q == FS_HI) ? VEC_HI : VEC_LO;
  assign ready_o     = run;
  assign pc_o        = pc_q;

  pc_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (push_data),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .depth_o (depth_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  pc_flag_banks #(.CTX_DEPTH(CTX_DEPTH)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enter_irq_i (run && op == OP_IRQ),
    .enter_nmi_i (run && op == OP_NMI),
    .leave_i     (run && op == OP_RETI),
    .we_i        (run && flag_we_i),
    .c_i         (carry_i),
    .z_i         (zero_i),
    .ctx_o       (ctx_o),
    .c_o         (carry_o),
    .z_o         (zero_o)
  );

  assert_ready_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_jump_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && op_i == 3'd2) |=> pc_o == $past(target_i));
  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (op_i == 3'd4 || op_i == 3'd7) && depth_o == '0) |=> (unf_o && $stable(pc_o)));
  assert_ignore_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && pmem_rd_o) |=> ($stable(pc_o) && depth_o == '0));
endmodule

// File: tb/sim_pc_seq.sv
module sim_pc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [11:0] tgt = '0;
  logic        fwe = 1'b0, cin = 1'b0, zin = 1'b0;
  logic [7:0]  pdata = '0;
  logic        prd, rdy, cout, zout, ovf, unf;
  logic [11:0] paddr, pc;
  logic [1:0]  ctx;
  logic [2:0]  depth;
  logic [7:0]  vlo = 8'h00, vhi = 8'h00;

  int nchk = 0, nerr = 0;
  int m_pc, m_cnt, m_ctx, m_ccnt;
  bit m_ovf, m_unf;
  int m_stk [6];
  int m_cstk [2];
  bit m_c [3], m_z [3], m_k [3];

  always #2 clk = ~clk;

  always @(posedge clk) if (prd) pdata <= (paddr == 12'hFFF) ? vhi : vlo;

  pc_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .target_i(tgt),
    .flag_we_i(fwe), .carry_i(cin), .zero_i(zin), .pmem_data_i(pdata),
    .pmem_rd_o(prd), .pmem_addr_o(paddr), .ready_o(rdy), .pc_o(pc),
    .carry_o(cout), .zero_o(zout), .ctx_o(ctx), .depth_o(depth),
    .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " R2 pc"}, int'(pc), m_pc);
    chk({tag, " R4 depth"}, int'(depth), m_cnt);
    chk({tag, " R4 ovf"}, int'(ovf), int'(m_ovf));
    chk({tag, " R5 unf"}, int'(unf), int'(m_unf));
    chk({tag, " R7 ctx"}, int'(ctx), m_ctx);
    if (m_k[m_ctx]) begin
      chk({tag, " R8 carry"}, int'(cout), int'(m_c[m_ctx]));
      chk({tag, " R8 zero"}, int'(zout), int'(m_z[m_ctx]));
    end
  endtask

  function automatic void m_push(input int v);
    for (int i = 5; i > 0; i--) m_stk[i] = m_stk[i-1];
    m_stk[0] = v;
    if (m_cnt == 6) m_ovf = 1'b1; else m_cnt++;
  endfunction

  function automatic void m_pop();
    if (m_cnt == 0) m_unf = 1'b1;
    else begin
      m_pc = m_stk[0];
      for (int i = 0; i < 5; i++) m_stk[i] = m_stk[i+1];
      m_cnt--;
    end
  endfunction

  function automatic void m_enter(input int n);
    m_cstk[1] = m_cstk[0];
    m_cstk[0] = m_ctx;
    if (m_ccnt < 2) m_ccnt++;
    m_ctx = n;
  endfunction

  function automatic void m_leave();
    if (m_ccnt > 0) begin
      m_ctx = m_cstk[0];
      m_cstk[0] = m_cstk[1];
      m_ccnt--;
    end else m_ctx = 0;
  endfunction

  // drive at a falling edge, predict, check at the next falling edge
  task automatic step(input int o, input int t, input bit we, input bit c, input bit z,
                      input string tag);
    op = 3'(o); tgt = 12'(t); fwe = we; cin = c; zin = z;
    if (we) begin m_c[m_ctx] = c; m_z[m_ctx] = z; m_k[m_ctx] = 1'b1; end
    case (o)
      1: m_pc = (m_pc + 1) & 12'hFFF;
      2: m_pc = t;
      3: begin m_push((m_pc + 2) & 12'hFFF); m_pc = t; end
      4: m_pop();
      5: begin m_push(m_pc); m_enter(1); m_pc = t; end
      6: begin m_push(m_pc); m_enter(2); m_pc = t; end
      7: begin m_pop(); m_leave(); end
      default: ;
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input logic [7:0] lo, input logic [7:0] hi);
    vlo = lo; vhi = hi;
    rst_n = 1'b0; op = 3'd0; fwe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 ready in reset", int'(rdy), 0);
    chk("R10 depth in reset", int'(depth), 0);
    chk("R10 ctx in reset", int'(ctx), 0);
    chk("R10 ovf/unf in reset", int'({ovf, unf}), 0);
    rst_n = 1'b1;
    op = 3'd3; tgt = 12'h123; fwe = 1'b1;   // R9: must be ignored
    chk("R1 first read addr", int'({prd, paddr}), 32'h1FFE);
    @(negedge clk);
    chk("R1 second read addr", int'({prd, paddr}), 32'h1FFF);
    chk("R1 not ready 1", int'(rdy), 0);
    @(negedge clk);
    chk("R1 not ready 2", int'(rdy), 0);
    @(negedge clk);
    chk("R1 ready", int'(rdy), 1);
    chk("R1 R9 start pc", int'(pc), int'({hi[3:0], lo}));
    chk("R9 no push during fetch", int'(depth), 0);
    chk("R10 ctx after fetch", int'(ctx), 0);
    m_pc = int'({hi[3:0], lo}); m_cnt = 0; m_ctx = 0; m_ccnt = 0;
    m_ovf = 0; m_unf = 0;
    for (int i = 0; i < 3; i++) m_k[i] = 1'b0;
    op = 3'd0; fwe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    @(negedge clk);
    do_reset(8'hA5, 8'hF3);

    // R2 increment, jump and wrap
    step(1, 0, 0, 0, 0, "inc");
    step(2, 12'hFFF, 0, 0, 0, "jmp");
    step(1, 0, 0, 0, 0, "wrap");
    chk("R2 wrap to zero", int'(pc), 0);

    // R3/R4 fill past six, R5 drain past empty
    for (int i = 0; i < 7; i++) step(3, 12'h100 + i * 16, 0, 0, 0, "call");
    chk("R4 ovf after seventh push", int'(ovf), 1);
    for (int i = 0; i < 6; i++) step(4, 0, 0, 0, 0, "ret");
    step(4, 0, 0, 0, 0, "ret empty");
    chk("R5 unf on empty", int'(unf), 1);

    // R6/R7/R8 nested contexts with flag pairs
    step(0, 0, 1, 1, 0, "norm flags");
    step(5, 12'hFF4, 1, 1, 0, "irq");
    step(0, 0, 1, 0, 1, "irq flags");
    step(6, 12'hFFC, 0, 0, 0, "nmi");
    step(0, 0, 1, 1, 1, "nmi flags");
    chk("R6 nmi ctx", int'(ctx), 2);
    step(7, 0, 0, 0, 0, "reti nmi");
    chk("R7 back to irq", int'(ctx), 1);
    chk("R8 irq pair kept", int'({cout, zout}), 2'b01);
    step(7, 0, 0, 0, 0, "reti irq");
    chk("R7 back to normal", int'(ctx), 0);
    chk("R8 normal pair kept", int'({cout, zout}), 2'b10);

    // random mix with periodic re-reset
    for (int n = 0; n < 4; n++) begin
      do_reset(8'($urandom), 8'($urandom));
      for (int i = 0; i < 800; i++) begin
        int r = int'($urandom_range(0, 9));
        int o = (r > 7) ? 1 : r;
        step(o, int'($urandom & 12'hFFF), bit'($urandom & 1), bit'($urandom & 1),
             bit'($urandom & 1), "rand");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule